// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a behavioural single-port synchronous SRAM for simulation. Its data word is 64 bits wide and is split into eight byte lanes. Every control, address and write-data input is captured on the rising clock edge. Read data then passes through an output register, so it leaves the block one edge after the command that asked for it.

An access starts with one of two address strobes. The processor-side strobe always starts a read. The controller-side strobe starts a write when a write condition is present and a read otherwise. After that, a two-bit burst counter steps through four word addresses in either linear or interleaved order. The counter can also hold its position so that wait states can be inserted. Five chip enables gate the starting strobes. Three write controls are decoded in priority order: a write-all input, a lane-write enable, and one write bit per lane.

The output enable and the sleep input remove the output at once, without waiting for a clock edge. The data bus is modelled as three signals: a data input, a data output and an output-valid flag. When the valid flag is low, the bus is undriven.

Top module: `sbsram_pipe`

## Requirements
- R1: The block counts as selected only while cs0_n=0, cs1=1, cs2_n=0, cs3=1 and cs4_n=0. A start strobe on an edge where the block is not selected ends any burst. Such an edge performs no access. Later edges without a start strobe then do nothing until a selected start arrives. A start strobe is either strobe_ctl_n=0, or strobe_cpu_n=0 together with cs0_n=0.
- R2: On a selected edge with strobe_cpu_n=0 and cs0_n=0, the block reads the word at addr. It does so even when write inputs are asserted on that edge.
- R3: Any edge without a start strobe, while a burst is active, continues that burst. If the write condition holds on that edge, the block writes the current burst address. A processor-strobe read followed by such an edge with step_n=1 therefore writes the address that was just read.
- R4: A selected edge with strobe_ctl_n=0 and no processor start is a start edge. It writes addr when the write condition holds and reads addr otherwise.
- R5: With wr_all_n=0, all eight lanes are written from din, whatever lane_wr_en_n and lane_wr_n are.
- R6: With wr_all_n=1 and lane_wr_en_n=0, each lane n whose lane_wr_n[n]=0 is written from din[8n+7:8n], and the other lanes keep their contents. With wr_all_n=1, the edge is a read in two cases: when lane_wr_en_n=1, or when all lane_wr_n bits are 1.
- R7: Take a read captured on edge k. Its data is loaded into the output register on edge k+1 and stays there until edge k+2.
- R8: dout_vld is 1 only when three things are true: the output register holds read data, oe_n=0, and sleep=0. oe_n acts without waiting for a clock edge. After a write, dout_vld stays 0. While dout_vld is 0, dout reads as zero.
- R9: With burst_ilv=0, each edge with step_n=0 during a burst advances a two-bit count. The access address is then the start address with its two low bits replaced by (low bits + count) mod 4, and its upper bits unchanged.
- R10: With burst_ilv=1, the two low bits of the access address are (low bits XOR count).
- R11: An edge of an active burst with step_n=1 accesses the same address as the previous access of that burst.
- R12: sleep=1 forces dout_vld to 0 at once. On an edge where sleep=1, no command is accepted, the pending access is dropped, and the memory keeps its contents. The burst state is held. A command on the first edge after sleep returns to 0 is accepted.
- R13: A read captured on the edge after a write to the same address returns the written lanes merged with the lanes that were left unchanged.
- R14: A synchronous rst=1 drops the pending access, clears the output register's valid flag and ends any burst. The memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Power-down request; removes the output without waiting for a clock edge |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low; acts without waiting for a clock edge |
| cs0_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| cs3 | input | 1 | Chip enable, active high |
| cs4_n | input | 1 | Chip enable, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, always starts a read |
| strobe_ctl_n | input | 1 | Controller address strobe, starts a read or a write |
| step_n | input | 1 | Advance the burst count when low |
| wr_all_n | input | 1 | Write all lanes when low |
| lane_wr_en_n | input | 1 | Enables the per-lane write bits when low |
| lane_wr_n | input | 8 | Per-lane write bits, active low, bit n controls bits 8n+7:8n |
| addr | input | AW | Word address captured by a start strobe |
| din | input | 64 | Write data |
| dout | output | 64 | Read data, zero when not driven |
| dout_vld | output | 1 | High when dout is driven |

## Verification
The clocked properties assume three things about the inputs: every input settles between edges, reset is held for at least one edge before the first command, and oe_n and sleep are evaluated at the edge in the same way as the other inputs. The burst-order property also assumes that burst_ilv does not change while a burst is active and a read is pending. To keep to this, the stimulus drives every input just after the rising edge. It also ends each burst with an unselected start strobe before it changes burst_ilv. Sleep and reset are raised and released on edge boundaries, so each edge is either fully asleep or fully awake.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int DW     = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] mask;
        logic [DW-1:0]    data;
    } stage_t;

    // low two address bits for a burst position
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

    // three-level write decode: write-all, then lane enable, then lane bits
    function automatic logic [LANES-1:0] lane_mask(input logic             all_n,
                                                   input logic             en_n,
                                                   input logic [LANES-1:0] bits_n);
        if (!all_n)
            return {LANES{1'b1}};
        else if (!en_n)
            return ~bits_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/sbsram_cmd_decode.sv
module sbsram_cmd_decode
    import sbsram_pkg::*;
(
    input  logic             sleep,
    input  logic             active,
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             cs2_n,
    input  logic             cs3,
    input  logic             cs4_n,
    input  logic             strobe_cpu_n,
    input  logic             strobe_ctl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output op_e              nxt_op,
    output logic             load,
    output logic             step,
    output logic             desel,
    output logic [LANES-1:0] mask
);

    logic sel_all;
    logic cpu_start;
    logic any_start;

    assign sel_all   = !cs0_n && cs1 && !cs2_n && cs3 && !cs4_n;
    assign cpu_start = !strobe_cpu_n && !cs0_n;
    assign any_start = cpu_start || !strobe_ctl_n;
    assign mask      = lane_mask(wr_all_n, lane_wr_en_n, lane_wr_n);

    always_comb begin
        nxt_op = OP_NOP;
        load   = 1'b0;
        step   = 1'b0;
        desel  = 1'b0;
        if (!sleep) begin
            if (any_start) begin
                if (sel_all) begin
                    load   = 1'b1;
                    nxt_op = (cpu_start || (mask == '0)) ? OP_RD : OP_WR;
                end else begin
                    desel = 1'b1;
                end
            end else if (active) begin
                step   = !step_n;
                nxt_op = (mask == '0) ? OP_RD : OP_WR;
            end
        end
    end

endmodule

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ilv,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    import sbsram_pkg::*;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    assign addr_out = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, ilv)};

    // R9: an advance moves the count by exactly one, wrapping at four
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R11: without load or advance the burst position is held
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int AW = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sleep,
    input  sbsram_pkg::op_e         op,
    input  logic [AW-1:0]           addr,
    input  logic [sbsram_pkg::LANES-1:0] mask,
    input  logic [sbsram_pkg::DW-1:0]    wdata,
    output logic [sbsram_pkg::DW-1:0]    rdata,
    output logic                    rvalid
);
    import sbsram_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic go;
    assign go = !rst && !sleep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (go && op == OP_WR && mask[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (go && op == OP_RD)
                out_q <= mem[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = out_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rvalid <= 1'b0;
        else
            rvalid <= !sleep && (op == OP_RD);
    end

endmodule

// File: rtl/sbsram_pipe.sv
module sbsram_pipe
    import sbsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep,
    input  logic          burst_ilv,
    input  logic          oe_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          cs3,
    input  logic          cs4_n,
    input  logic          strobe_cpu_n,
    input  logic          strobe_ctl_n,
    input  logic          step_n,
    input  logic          wr_all_n,
    input  logic          lane_wr_en_n,
    input  logic [7:0]    lane_wr_n,
    input  logic [AW-1:0] addr,
    input  logic [63:0]   din,
    output logic [63:0]   dout,
    output logic          dout_vld
);

    op_e              nxt_op;
    logic             load;
    logic             step;
    logic             desel;
    logic [LANES-1:0] mask;
    logic             active_q;
    stage_t           stage_q;
    logic [AW-1:0]    acc_addr;
    logic [DW-1:0]    rd_data;
    logic             rd_valid;

    sbsram_cmd_decode u_dec (
        .sleep        (sleep),
        .active       (active_q),
        .cs0_n        (cs0_n),
        .cs1          (cs1),
        .cs2_n        (cs2_n),
        .cs3          (cs3),
        .cs4_n        (cs4_n),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .step_n       (step_n),
        .wr_all_n     (wr_all_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_wr_n    (lane_wr_n),
        .nxt_op       (nxt_op),
        .load         (load),
        .step         (step),
        .desel        (desel),
        .mask         (mask)
    );

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= 1'b0;
        else if (load)
            active_q <= 1'b1;
        else if (desel)
            active_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q.op   <= OP_NOP;
            stage_q.mask <= '0;
            stage_q.data <= '0;
        end else begin
            stage_q.op   <= nxt_op;
            stage_q.mask <= mask;
            stage_q.data <= din;
        end
    end

    sbsram_burst_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ilv      (burst_ilv),
        .load     (load),
        .step     (step),
        .addr_in  (addr),
        .addr_out (acc_addr)
    );

    sbsram_array #(.AW(AW)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .sleep  (sleep),
        .op     (stage_q.op),
        .addr   (acc_addr),
        .mask   (stage_q.mask),
        .wdata  (stage_q.data),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    assign dout_vld = rd_valid && !oe_n && !sleep;
    assign dout     = dout_vld ? rd_data : '0;

    // R1: an unselected start ends the burst and queues no access
    a_r1_deselect: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strobe_ctl_n && !(cs1 && cs3 && !cs0_n && !cs2_n && !cs4_n))
        |=> (!active_q && stage_q.op == OP_NOP));

    // R2: a selected processor strobe queues a read
    a_r2_cpu_read: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strobe_cpu_n && !cs0_n && cs1 && !cs2_n && cs3 && !cs4_n)
        |=> (stage_q.op == OP_RD));

    // R8: a completed write leaves the output undriven
    a_r8_quiet_after_write: assert property (@(posedge clk) disable iff (rst)
        (stage_q.op == OP_WR) |=> !dout_vld);

    // R8: output enable high keeps the bus undriven
    a_r8_oe_gate: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_vld);

    // R12: nothing is driven while asleep
    a_r12_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_vld);

endmodule

// File: tb/sim_sbsram_pipe.sv
module sim_sbsram_pipe;

    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep = 1'b0;
    logic          burst_ilv = 1'b0;
    logic          oe_n = 1'b0;
    logic          cs0_n = 1'b0, cs1 = 1'b1, cs2_n = 1'b0, cs3 = 1'b1, cs4_n = 1'b0;
    logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, step_n = 1'b1;
    logic          wr_all_n = 1'b1, lane_wr_en_n = 1'b1;
    logic [7:0]    lane_wr_n = 8'hFF;
    logic [AW-1:0] addr = '0;
    logic [63:0]   din = '0;
    logic [63:0]   dout;
    logic          dout_vld;

    sbsram_pipe #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .sleep(sleep), .burst_ilv(burst_ilv), .oe_n(oe_n),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .cs3(cs3), .cs4_n(cs4_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    always #5 clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    string cur_req = "R14";

    // behavioural reference: words, pending access, burst position
    logic [63:0]   mm [NW];
    int            m_pend = 0;          // 0 none, 1 read, 2 write
    logic [AW-1:0] m_paddr = '0;
    logic [7:0]    m_pmask = '0;
    logic [63:0]   m_pdata = '0;
    bit            m_outv = 1'b0;
    logic [63:0]   m_outd = '0;
    bit            m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_outv = 1'b0; m_act = 1'b0;
        end else if (sleep) begin
            m_pend = 0; m_outv = 1'b0;
        end else begin
            bit   sel, cpu, start, wr;
            logic [7:0] msk;
            int   low;
            if (m_pend == 2)
                for (int i = 0; i < 8; i++)
                    if (m_pmask[i]) mm[m_paddr][8*i +: 8] = m_pdata[8*i +: 8];
            m_outv = (m_pend == 1);
            if (m_pend == 1) m_outd = mm[m_paddr];
            sel   = !cs0_n && cs1 && !cs2_n && cs3 && !cs4_n;
            cpu   = !strobe_cpu_n && !cs0_n;
            start = cpu || !strobe_ctl_n;
            if (!wr_all_n) msk = 8'hFF;
            else if (!lane_wr_en_n) msk = ~lane_wr_n;
            else msk = 8'h00;
            wr = (msk != 8'h00);
            m_pend = 0;
            if (start) begin
                if (sel) begin
                    m_act = 1'b1; m_base = addr; m_cnt = 0;
                    m_pend = (cpu || !wr) ? 1 : 2;
                end else m_act = 1'b0;
            end else if (m_act) begin
                if (!step_n) m_cnt = (m_cnt + 1) % 4;
                m_pend = wr ? 2 : 1;
            end
            low = burst_ilv ? (int'(m_base[1:0]) ^ m_cnt) : ((int'(m_base[1:0]) + m_cnt) % 4);
            m_paddr = {m_base[AW-1:2], 2'(low)};
            m_pmask = msk;
            m_pdata = din;
        end
    end

    // every-clock comparison, sampled away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_v;
            exp_v = m_outv && !oe_n && !sleep;
            total++;
            if (dout_vld !== exp_v || (exp_v && dout !== m_outd)) begin
                bad++;
                $display("FAIL %s: vld=%0b dout=%h expected vld=%0b dout=%h",
                         cur_req, dout_vld, dout, exp_v, exp_v ? m_outd : 64'h0);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic drive(input logic cpu_n, input logic ctl_n, input logic stp_n,
                         input logic gwn, input logic ben, input logic [7:0] bwn,
                         input logic [AW-1:0] a, input logic [63:0] d);
        strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n; step_n = stp_n;
        wr_all_n = gwn; lane_wr_en_n = ben; lane_wr_n = bwn; addr = a; din = d;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1, 1, 1, 1, 1, 8'hFF, '0, '0);
    endtask

    // unselected controller strobe: ends any burst (R1)
    task automatic end_burst();
        cs0_n = 1'b1;
        drive(1, 0, 1, 1, 1, 8'hFF, '0, '0);
        cs0_n = 1'b0;
        idle(2);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        drive(1, 0, 1, 1, 1, 8'hFF, a, '0);
        idle(2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R14: reset state has nothing driven
        total++;
        if (dout_vld !== 1'b0) begin
            bad++;
            $display("FAIL R14: dout_vld=%0b expected=0", dout_vld);
        end

        // R5: fill every word with write-all starts
        cur_req = "R5";
        for (int i = 0; i < NW; i++)
            drive(1, 0, 1, 0, 1, 8'h00, AW'(i), {32'hA5A50000 + 32'(i), 32'(i * 7919)});
        end_burst();
        // R4: controller strobe without write condition reads
        cur_req = "R4";
        rd(6'd5); rd(6'd63);
        end_burst();

        // R6: lane writes on lanes 0 and 7, then lane bits ignored when enable high
        cur_req = "R6";
        drive(1, 0, 1, 1, 0, 8'h7E, 6'd5, 64'h1111_2222_3333_4444);
        idle(1);
        rd(6'd5);
        drive(1, 0, 1, 1, 1, 8'h00, 6'd5, 64'hDEAD_BEEF_DEAD_BEEF);
        idle(1);
        rd(6'd5);
        end_burst();

        // R13: read on the edge right after a lane write to the same word
        cur_req = "R13";
        drive(1, 0, 1, 1, 0, 8'hF0, 6'd7, 64'hCAFE_F00D_0BAD_BEEF);
        drive(1, 0, 1, 1, 1, 8'hFF, 6'd7, '0);
        idle(2);
        end_burst();

        // R2 then R3: processor strobe reads despite write-all, next edge writes
        cur_req = "R2";
        drive(0, 1, 1, 0, 1, 8'h00, 6'd20, 64'h5555_5555_5555_5555);
        cur_req = "R3";
        drive(1, 1, 1, 0, 1, 8'hFF, '0, 64'h0123_4567_89AB_CDEF);
        idle(2);
        rd(6'd20);
        end_burst();

        // R9: linear burst write then read from low bits 2
        cur_req = "R9";
        burst_ilv = 1'b0;
        drive(1, 0, 1, 0, 1, 8'hFF, 6'd10, 64'h1000);
        for (int i = 1; i < 4; i++) drive(1, 1, 0, 0, 1, 8'hFF, '0, 64'h1000 + 64'(i));
        drive(1, 0, 1, 1, 1, 8'hFF, 6'd10, '0);
        for (int i = 1; i < 5; i++) drive(1, 1, 0, 1, 1, 8'hFF, '0, '0);
        end_burst();

        // R10: interleaved burst from low bits 1
        cur_req = "R10";
        burst_ilv = 1'b1;
        drive(1, 0, 1, 0, 1, 8'hFF, 6'd13, 64'h2000);
        for (int i = 1; i < 4; i++) drive(1, 1, 0, 0, 1, 8'hFF, '0, 64'h2000 + 64'(i));
        drive(0, 1, 1, 1, 1, 8'hFF, 6'd13, '0);
        for (int i = 1; i < 4; i++) drive(1, 1, 0, 1, 1, 8'hFF, '0, '0);
        end_burst();
        burst_ilv = 1'b0;

        // R11: suspended burst repeats its address, then a suspended write
        cur_req = "R11";
        drive(1, 0, 1, 1, 1, 8'hFF, 6'd30, '0);
        drive(1, 1, 0, 1, 1, 8'hFF, '0, '0);
        idle(3);
        drive(1, 1, 1, 1, 0, 8'hFD, '0, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(2);
        end_burst();

        // R7 and R8: output enable removes data during a read burst
        cur_req = "R8";
        drive(1, 0, 1, 1, 1, 8'hFF, 6'd40, '0);
        oe_n = 1'b1;
        drive(1, 1, 0, 1, 1, 8'hFF, '0, '0);
        idle(1);
        #2 oe_n = 1'b0;
        tick();
        cur_req = "R7";
        idle(2);
        end_burst();

        // R1: unselected start with write; following edges inert
        cur_req = "R1";
        cs3 = 1'b0;
        drive(1, 0, 1, 0, 1, 8'hFF, 6'd44, 64'h9999);
        drive(1, 1, 0, 0, 1, 8'hFF, '0, 64'h8888);
        cs3 = 1'b1;
        idle(3);
        rd(6'd44);
        end_burst();

        // R12: sleep mid-burst, write attempt ignored, first edge after wake accepted
        cur_req = "R12";
        drive(1, 0, 1, 1, 1, 8'hFF, 6'd50, '0);
        sleep = 1'b1;
        drive(1, 0, 1, 0, 1, 8'hFF, 6'd50, 64'h7777);
        idle(2);
        sleep = 1'b0;
        drive(1, 0, 1, 1, 1, 8'hFF, 6'd50, '0);
        idle(2);
        end_burst();

        // R14: reset drops a pending read, memory survives
        cur_req = "R14";
        drive(1, 0, 1, 1, 1, 8'hFF, 6'd5, '0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        idle(2);
        rd(6'd5);
        end_burst();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule